// File: doc/BRIEF.md
# Streaming Three-Product Complex Multiplier

This block forms the complex product of a stream of I/Q samples and a stream of complex coefficients. One full product leaves the block on every clock that is not stalled. Only three real multipliers are used: the sample-real times coefficient-real, the sample-imaginary times coefficient-imaginary, and the product of the two pre-added sums. The imaginary part comes from subtracting the first two from the third. Every pre-add, multiply, add and subtract is followed by a register. The pipeline is six stages deep.

Operands and results are signed fixed-point values with one integer bit and DW-1 fraction bits. The wide intermediate result is rounded half away from zero back to DW bits and then clamped to the signed range. Sample and coefficient arrive on two valid/ready streams that transfer together. One result stream with valid/ready backpressure leaves the block. A single advance condition freezes every stage together when the result is held.

Top module: `cmul3_pipe`

## Requirements
- R1: With sample a + jb and coefficient c + jd, the real output equals round(ac − bd) scaled down by 2^(DW−1), before saturation.
- R2: The imaginary output equals round(ad + bc) scaled down by 2^(DW−1), before saturation.
- R3: Rounding is half away from zero. A value x in units of 2^−2(DW−1) maps to sign(x)·floor(|x|/2^(DW−1) + 1/2). For DW=16: 1×16384 gives 1, −1×16384 gives −1, and 1×16383 gives 0.
- R4: A rounded result outside the signed DW-bit range is clamped to the most positive or most negative code. With DW=16, (−32768)×(−32768) gives real 0x7FFF.
- R5: In both input words and in the output word, bits [DW−1:0] hold the real (I) part and bits [2DW−1:DW] hold the imaginary (Q) part, all in two's complement.
- R6: With the result side ready, a pair accepted on clock edge k is presented with m_valid high after edge k+5. This is a fixed latency of six register stages.
- R7: With both inputs valid and m_ready held high, one pair is accepted and one result is delivered on every clock.
- R8: A pair transfers only on an edge where both input valids are high. s_smp_ready equals s_coef_valid AND (NOT m_valid OR m_ready), and s_coef_ready equals s_smp_valid AND (NOT m_valid OR m_ready).
- R9: While m_valid is high and m_ready is low, m_data holds its value, m_valid stays high, and both input readies are low.
- R10: Reset clears every pipeline valid flag. m_valid is low during reset and stays low after it until a new pair has gone through.
- R11: Results leave in acceptance order. Each accepted pair yields exactly one result, and no result appears without a pair behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_smp_valid | input | 1 | Sample word valid |
| s_smp_ready | output | 1 | Sample word accepted when high with valid |
| s_smp_data | input | 2*DW | Sample, I in low half, Q in high half |
| s_coef_valid | input | 1 | Coefficient word valid |
| s_coef_ready | output | 1 | Coefficient word accepted when high with valid |
| s_coef_data | input | 2*DW | Coefficient, real in low half, imaginary in high half |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Downstream accepts result |
| m_data | output | 2*DW | Result, I in low half, Q in high half |

## Verification
Most internal faults surface on m_data six edges after the pair that meets them. Examples are a wrong sign extension in the pre-add, a sum reused for the wrong lane, or a rounding bias applied with the wrong sign. The bench computes each expected product with wide integer arithmetic and compares every delivered result in order. A broken valid chain or stall enable shows up sooner. It can appear on the next edge as a changed m_data while held, a ready that is high during a stall, or a result that arrives with no matching pair. Extreme operands drive the rounding and clamping paths through the same comparison.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;
   // register stages from input capture to result register
   localparam int unsigned CMUL3_STAGES = 6;
   // lane indices inside the packed words
   localparam int unsigned LANE_I = 0;
   localparam int unsigned LANE_Q = 1;
   localparam int unsigned LANES  = 2;
endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd #(
   parameter int unsigned DW = 16
) (
   input  logic                 clk,
   input  logic                 en,
   input  logic signed [DW-1:0] a_i,
   input  logic signed [DW-1:0] b_i,
   input  logic signed [DW-1:0] c_i,
   input  logic signed [DW-1:0] d_i,
   output logic signed [DW:0]   ab_o,
   output logic signed [DW:0]   cd_o,
   output logic signed [DW-1:0] a_o,
   output logic signed [DW-1:0] b_o,
   output logic signed [DW-1:0] c_o,
   output logic signed [DW-1:0] d_o
);
   logic signed [DW:0] ab_d;
   logic signed [DW:0] cd_d;

   // one guard bit so the sum of two full-scale values never wraps
   assign ab_d = {a_i[DW-1], a_i} + {b_i[DW-1], b_i};
   assign cd_d = {c_i[DW-1], c_i} + {d_i[DW-1], d_i};

   always_ff @(posedge clk) begin
      if (en) begin
         ab_o <= ab_d;
         cd_o <= cd_d;
         a_o  <= a_i;
         b_o  <= b_i;
         c_o  <= c_i;
         d_o  <= d_i;
      end
   end
endmodule

// File: rtl/cmul3_mult3.sv
module cmul3_mult3 #(
   parameter int unsigned DW = 16
) (
   input  logic                     clk,
   input  logic                     en,
   input  logic signed [DW-1:0]     a_i,
   input  logic signed [DW-1:0]     b_i,
   input  logic signed [DW-1:0]     c_i,
   input  logic signed [DW-1:0]     d_i,
   input  logic signed [DW:0]       ab_i,
   input  logic signed [DW:0]       cd_i,
   output logic signed [2*DW-1:0]   ac_o,
   output logic signed [2*DW-1:0]   bd_o,
   output logic signed [2*DW+1:0]   k_o
);
   localparam int unsigned PW = 2*DW;
   localparam int unsigned KW = 2*DW + 2;

   logic signed [PW-1:0] ac_d;
   logic signed [PW-1:0] bd_d;
   logic signed [KW-1:0] k_d;

   // operands widened to the product width so the low bits are exact
   assign ac_d = $signed({{DW{a_i[DW-1]}}, a_i}) * $signed({{DW{c_i[DW-1]}}, c_i});
   assign bd_d = $signed({{DW{b_i[DW-1]}}, b_i}) * $signed({{DW{d_i[DW-1]}}, d_i});
   assign k_d  = $signed({{(KW-DW-1){ab_i[DW]}}, ab_i})
               * $signed({{(KW-DW-1){cd_i[DW]}}, cd_i});

   always_ff @(posedge clk) begin
      if (en) begin
         ac_o <= ac_d;
         bd_o <= bd_d;
         k_o  <= k_d;
      end
   end
endmodule

// File: rtl/cmul3_combine.sv
module cmul3_combine #(
   parameter int unsigned DW = 16
) (
   input  logic                    clk,
   input  logic                    en,
   input  logic signed [2*DW-1:0]  ac_i,
   input  logic signed [2*DW-1:0]  bd_i,
   input  logic signed [2*DW+1:0]  k_i,
   output logic signed [2*DW+2:0]  re_o,
   output logic signed [2*DW+2:0]  im_o
);
   localparam int unsigned PW = 2*DW;
   localparam int unsigned KW = 2*DW + 2;
   localparam int unsigned SW = 2*DW + 3;

   logic signed [SW-1:0] ac_x;
   logic signed [SW-1:0] bd_x;
   logic signed [SW-1:0] k_x;
   logic signed [SW-1:0] re_a;
   logic signed [SW-1:0] sum_a;
   logic signed [SW-1:0] k_a;

   assign ac_x = {{(SW-PW){ac_i[PW-1]}}, ac_i};
   assign bd_x = {{(SW-PW){bd_i[PW-1]}}, bd_i};
   assign k_x  = {{(SW-KW){k_i[KW-1]}}, k_i};

   // first add stage: real difference and the sum used by the imaginary lane
   always_ff @(posedge clk) begin
      if (en) begin
         re_a  <= ac_x - bd_x;
         sum_a <= ac_x + bd_x;
         k_a   <= k_x;
      end
   end

   // second add stage: imaginary part from the pre-added product
   always_ff @(posedge clk) begin
      if (en) begin
         re_o <= re_a;
         im_o <= k_a - sum_a;
      end
   end
endmodule

// File: rtl/cmul3_rndsat.sv
module cmul3_rndsat #(
   parameter int unsigned IW   = 35,
   parameter int unsigned OW   = 16,
   parameter int unsigned FRAC = 15
) (
   input  logic                 clk,
   input  logic                 en,
   input  logic signed [IW-1:0] x_i,
   output logic        [OW-1:0] y_o
);
   localparam int unsigned RW = IW + 1;
   localparam logic [RW-1:0] HALF = RW'(1) << (FRAC - 1);
   localparam logic [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
   localparam logic [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

   logic signed [RW-1:0] xe;
   logic signed [RW-1:0] bias;
   logic signed [RW-1:0] sum;
   logic signed [RW-1:0] shr;
   logic                 fits;
   logic [OW-1:0]        y_d;

   assign xe   = {x_i[IW-1], x_i};
   // a negative value takes one less than half so a tie moves away from zero
   assign bias = x_i[IW-1] ? $signed(HALF - RW'(1)) : $signed(HALF);
   assign sum  = xe + bias;
   assign shr  = sum >>> FRAC;
   assign fits = (&shr[RW-1:OW-1]) || !(|shr[RW-1:OW-1]);

   always_comb begin
      if (fits) begin
         y_d = shr[OW-1:0];
      end else if (shr[RW-1]) begin
         y_d = MINV;
      end else begin
         y_d = MAXV;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         y_o <= y_d;
      end
   end
endmodule

// File: rtl/cmul3_pipe.sv
module cmul3_pipe
   import cmul3_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            s_smp_valid,
   output logic            s_smp_ready,
   input  logic [2*DW-1:0] s_smp_data,
   input  logic            s_coef_valid,
   output logic            s_coef_ready,
   input  logic [2*DW-1:0] s_coef_data,
   output logic            m_valid,
   input  logic            m_ready,
   output logic [2*DW-1:0] m_data
);
   localparam int unsigned PW   = 2*DW;
   localparam int unsigned KW   = 2*DW + 2;
   localparam int unsigned SW   = 2*DW + 3;
   localparam int unsigned FRAC = DW - 1;
   localparam int unsigned NST  = CMUL3_STAGES;

   if (DW < 4 || DW > 24) begin : g_bad_dw
      $error("cmul3_pipe: DW must lie in 4..24");
   end
   if (NST < 2) begin : g_bad_nst
      $error("cmul3_pipe: stage count too small");
   end

   logic           adv;
   logic           take;
   logic [NST-1:0] vld;

   // one advance condition moves or freezes every stage together
   assign adv          = !vld[NST-1] || m_ready;
   assign take         = adv && s_smp_valid && s_coef_valid;
   assign s_smp_ready  = adv && s_coef_valid;
   assign s_coef_ready = adv && s_smp_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
      end else if (adv) begin
         vld <= {vld[NST-2:0], take};
      end
   end

   // stage 1: operand capture
   logic signed [DW-1:0] a_r, b_r, c_r, d_r;
   always_ff @(posedge clk) begin
      if (adv) begin
         a_r <= s_smp_data[DW-1:0];
         b_r <= s_smp_data[PW-1:DW];
         c_r <= s_coef_data[DW-1:0];
         d_r <= s_coef_data[PW-1:DW];
      end
   end

   // stage 2: pre-add
   logic signed [DW:0]   ab_p, cd_p;
   logic signed [DW-1:0] a_p, b_p, c_p, d_p;
   cmul3_preadd #(.DW(DW)) u_pre (
      .clk  (clk),
      .en   (adv),
      .a_i  (a_r),
      .b_i  (b_r),
      .c_i  (c_r),
      .d_i  (d_r),
      .ab_o (ab_p),
      .cd_o (cd_p),
      .a_o  (a_p),
      .b_o  (b_p),
      .c_o  (c_p),
      .d_o  (d_p)
   );

   // stage 3: three real products
   logic signed [PW-1:0] ac_m, bd_m;
   logic signed [KW-1:0] k_m;
   cmul3_mult3 #(.DW(DW)) u_mul (
      .clk  (clk),
      .en   (adv),
      .a_i  (a_p),
      .b_i  (b_p),
      .c_i  (c_p),
      .d_i  (d_p),
      .ab_i (ab_p),
      .cd_i (cd_p),
      .ac_o (ac_m),
      .bd_o (bd_m),
      .k_o  (k_m)
   );

   // stages 4 and 5: add and subtract
   logic signed [SW-1:0] re_c, im_c;
   cmul3_combine #(.DW(DW)) u_cmb (
      .clk  (clk),
      .en   (adv),
      .ac_i (ac_m),
      .bd_i (bd_m),
      .k_i  (k_m),
      .re_o (re_c),
      .im_o (im_c)
   );

   // stage 6: round and clamp, one instance per lane
   logic signed [SW-1:0] lane_in  [LANES];
   logic        [DW-1:0] lane_out [LANES];
   assign lane_in[LANE_I] = re_c;
   assign lane_in[LANE_Q] = im_c;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      cmul3_rndsat #(.IW(SW), .OW(DW), .FRAC(FRAC)) u_rs (
         .clk (clk),
         .en  (adv),
         .x_i (lane_in[g]),
         .y_o (lane_out[g])
      );
   end

   assign m_valid = vld[NST-1];
   assign m_data  = {lane_out[LANE_Q], lane_out[LANE_I]};
endmodule

// File: rtl/cmul3_pipe_chk.sv
module cmul3_pipe_chk #(
   parameter int unsigned DW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            s_smp_valid,
   input logic            s_smp_ready,
   input logic            s_coef_valid,
   input logic            s_coef_ready,
   input logic            m_valid,
   input logic            m_ready,
   input logic [2*DW-1:0] m_data
);
   localparam int unsigned NST = cmul3_pkg::CMUL3_STAGES;

   logic       in_x, out_x;
   logic [4:0] inflight;

   assign in_x  = s_smp_valid && s_smp_ready;
   assign out_x = m_valid && m_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight <= '0;
      end else begin
         inflight <= inflight + {4'd0, in_x} - {4'd0, out_x};
      end
   end

   AST_JOINT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (s_smp_valid && s_smp_ready) == (s_coef_valid && s_coef_ready)); // R8

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R9

   AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |-> (!s_smp_ready && !s_coef_ready)); // R9

   AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (inflight != 5'd0)); // R11

   AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= 5'(NST)); // R7
endmodule

bind cmul3_pipe cmul3_pipe_chk #(.DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .s_smp_valid  (s_smp_valid),
   .s_smp_ready  (s_smp_ready),
   .s_coef_valid (s_coef_valid),
   .s_coef_ready (s_coef_ready),
   .m_valid      (m_valid),
   .m_ready      (m_ready),
   .m_data       (m_data)
);

// File: tb/cmul3_pipe_bench.sv
module cmul3_pipe_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_smp_valid = 1'b0;
   logic        s_smp_ready;
   logic [31:0] s_smp_data = '0;
   logic        s_coef_valid = 1'b0;
   logic        s_coef_ready;
   logic [31:0] s_coef_data = '0;
   logic        m_valid;
   logic        m_ready = 1'b0;
   logic [31:0] m_data;

   cmul3_pipe #(.DW(DW)) u_cmul3_pipe (
      .clk          (clk),
      .rst_n        (rst_n),
      .s_smp_valid  (s_smp_valid),
      .s_smp_ready  (s_smp_ready),
      .s_smp_data   (s_smp_data),
      .s_coef_valid (s_coef_valid),
      .s_coef_ready (s_coef_ready),
      .s_coef_data  (s_coef_data),
      .m_valid      (m_valid),
      .m_ready      (m_ready),
      .m_data       (m_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [31:0] exp_q[$];
   bit          hold_pend = 1'b0;
   logic [31:0] hold_val = '0;
   bit          last_in, last_out;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] rs(input longint x);
      longint q;
      if (x >= 0) q = (x + 16384) / 32768;
      else        q = -((-x + 16384) / 32768);
      if (q > 32767)  q = 32767;
      if (q < -32768) q = -32768;
      return q[15:0];
   endfunction

   function automatic logic [31:0] ref_mul(input logic [31:0] s, input logic [31:0] c);
      longint a, b, cr, ci;
      a  = longint'($signed(s[15:0]));
      b  = longint'($signed(s[31:16]));
      cr = longint'($signed(c[15:0]));
      ci = longint'($signed(c[31:16]));
      return {rs(a*ci + b*cr), rs(a*cr - b*ci)};
   endfunction

   function automatic logic [15:0] pick();
      case ($urandom % 8)
         0: return 16'h8000;
         1: return 16'h7FFF;
         2: return 16'h0000;
         3: return 16'hFFFF;
         default: return 16'($urandom);
      endcase
   endfunction

   task automatic cycle(input bit sv, input logic [31:0] sd, input bit cv,
                        input logic [31:0] cd, input bit mr);
      bit adv_e;
      logic [31:0] e;
      @(negedge clk);
      s_smp_valid = sv; s_smp_data = sd;
      s_coef_valid = cv; s_coef_data = cd;
      m_ready = mr;
      #1;
      adv_e = !m_valid || m_ready;
      chk(s_smp_ready == (adv_e && cv), "R8 s_smp_ready", 64'(s_smp_ready), 64'(adv_e && cv));
      chk(s_coef_ready == (adv_e && sv), "R8 s_coef_ready", 64'(s_coef_ready), 64'(adv_e && sv));
      if (hold_pend) begin
         chk(m_valid && m_data == hold_val, "R9 hold", 64'(m_data), 64'(hold_val));
         hold_pend = 1'b0;
      end
      if (m_valid && !m_ready) begin
         hold_pend = 1'b1;
         hold_val  = m_data;
      end
      last_out = m_valid && m_ready;
      last_in  = s_smp_valid && s_smp_ready && s_coef_valid && s_coef_ready;
      if (m_valid && exp_q.size() == 0) begin
         chk(1'b0, "R11 result without pair", 64'(m_data), 64'd0);
      end else if (last_out) begin
         e = exp_q.pop_front();
         chk(m_data == e, "R1/R2 product", 64'(m_data), 64'(e));
      end
      if (last_in) exp_q.push_back(ref_mul(sd, cd));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      s_smp_valid = 1'b0; s_coef_valid = 1'b0; m_ready = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(m_valid == 1'b0, "R10 m_valid in reset", 64'(m_valid), 64'd0);
      chk(s_smp_ready == 1'b0 && s_coef_ready == 1'b0, "R10 readies in reset",
          64'({s_smp_ready, s_coef_ready}), 64'd0);
      exp_q.delete();
      hold_pend = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic one_shot(input logic [31:0] sd, input logic [31:0] cd,
                           input logic [31:0] exp, input string req);
      int lat = 0;
      cycle(1'b1, sd, 1'b1, cd, 1'b1);
      chk(last_in, "R8 pair taken", 64'(last_in), 64'd1);
      for (int k = 1; k <= 10; k++) begin
         cycle(1'b0, '0, 1'b0, '0, 1'b1);
         if (m_valid && lat == 0) begin
            lat = k;
            chk(m_data == exp, req, 64'(m_data), 64'(exp));
         end
      end
      chk(lat == 6, "R6 latency", 64'(lat), 64'd6);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int nin, nout;
      void'($urandom(32'h5EED_0C3A));
      do_reset();
      repeat (4) cycle(1'b0, '0, 1'b0, '0, 1'b1);
      chk(m_valid == 1'b0, "R10 idle after reset", 64'(m_valid), 64'd0);

      // directed corner cases: {imag, real} packing per R5
      one_shot({16'h0000, 16'h0001}, {16'h0000, 16'h4000}, 32'h0000_0001, "R3 +half rounds up");
      one_shot({16'h0000, 16'hFFFF}, {16'h0000, 16'h4000}, 32'h0000_FFFF, "R3 -half rounds away");
      one_shot({16'h0000, 16'h0001}, {16'h0000, 16'h3FFF}, 32'h0000_0000, "R3 below half");
      one_shot({16'h0000, 16'h8000}, {16'h0000, 16'h8000}, 32'h0000_7FFF, "R4 real clamp");
      one_shot({16'h8000, 16'h8000}, {16'h8000, 16'h8000}, 32'h7FFF_0000, "R4 imag clamp");
      one_shot({16'h8000, 16'h8000}, {16'h7FFF, 16'h7FFF}, 32'h8000_0000, "R4 negative clamp");
      one_shot({16'h0000, 16'h4000}, {16'h4000, 16'h0000}, 32'h2000_0000, "R5 field placement");
      one_shot({16'h4000, 16'h4000}, {16'h4000, 16'h4000}, 32'h4000_0000, "R2 imag sum");
      one_shot({16'h2000, 16'h4000}, {16'hE000, 16'h4000}, 32'h0000_2800, "R1 real difference");

      // one valid alone must not transfer
      cycle(1'b1, 32'h1234_5678, 1'b0, '0, 1'b1);
      chk(!last_in && !s_smp_ready, "R8 sample alone", 64'(s_smp_ready), 64'd0);
      cycle(1'b0, '0, 1'b1, 32'h1111_2222, 1'b1);
      chk(!last_in && !s_coef_ready, "R8 coef alone", 64'(s_coef_ready), 64'd0);
      repeat (8) cycle(1'b0, '0, 1'b0, '0, 1'b1);

      // full-rate streaming
      nin = 0; nout = 0;
      for (int i = 0; i < 56; i++) begin
         if (i < 50) cycle(1'b1, {pick(), pick()}, 1'b1, {pick(), pick()}, 1'b1);
         else        cycle(1'b0, '0, 1'b0, '0, 1'b1);
         nin  += int'(last_in);
         nout += int'(last_out);
      end
      chk(nin == 50, "R7 one accept per clock", 64'(nin), 64'd50);
      chk(nout == 50, "R7 one result per clock", 64'(nout), 64'd50);

      // random valids and backpressure
      for (int i = 0; i < 3000; i++) begin
         cycle(($urandom % 4) != 0, {pick(), pick()}, ($urandom % 4) != 0,
               {pick(), pick()}, ($urandom % 10) < 7);
      end
      for (int i = 0; i < 30; i++) cycle(1'b0, '0, 1'b0, '0, 1'b1);
      chk(exp_q.size() == 0, "R11 all results delivered", 64'(exp_q.size()), 64'd0);

      // reset with pairs still in flight
      for (int i = 0; i < 4; i++) cycle(1'b1, {pick(), pick()}, 1'b1, {pick(), pick()}, 1'b0);
      do_reset();
      nout = 0;
      for (int i = 0; i < 8; i++) begin
         cycle(1'b0, '0, 1'b0, '0, 1'b1);
         nout += int'(m_valid);
      end
      chk(nout == 0, "R10 flushed by reset", 64'(nout), 64'd0);
      one_shot({16'h0000, 16'h0001}, {16'h0000, 16'h4000}, 32'h0000_0001, "R10 works after reset");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule